// File: doc/BRIEF.md
# ADC conversion control unit

This block is the bus-side control for a 10-bit analog-to-digital converter inside a small microcontroller. Software sees two byte-wide special-function registers: a control/status register and a clock-divider register. A write that sets the start bit, with the converter enabled, begins one conversion on the chosen channel. The block divides the system clock into conversion ticks, counts a fixed number of ticks, and then captures the sample of the chosen channel into a result port.

At the end of a conversion, hardware clears the start bit, sets a sticky end-of-conversion flag and can raise an interrupt. Software may also request that the CPU be held in a pseudo-idle state while the conversion runs. Hardware releases that request when the conversion completes. The analog front end is modelled as one 10-bit digital sample input per channel.

Top module: `adc_ctl_unit`

## Requirements
- R1: After reset, the control register (address F3h) and the divider register (address F2h) both read 00h. `standby` is 1, and `irq`, `cpu_suspend`, `result_hi` and `result_lo` are all 0.
- R2: Control bits 7, 2 and 1, and divider bits 7 to 5, always read 0 whatever is written to them. A read of any other address returns 00h.
- R3: A control write with bit 3 (start) = 1 and bit 5 (enable) = 1, made while idle, starts a conversion. Bit 3 then reads 1 for exactly 11 x (divider+1) system clocks and reads 0 afterwards.
- R4: A control write with start = 1 and enable = 0 is ignored. Bit 3 stays 0 and no conversion takes place.
- R5: A start written while a conversion is busy has no effect. The running conversion keeps its original length.
- R6: Bit 4 (end-of-conversion) is set when a conversion completes. A control write with bit 4 = 0 clears it, and a write with bit 4 = 1 leaves it unchanged. If a clear coincides with completion, the flag ends up set.
- R7: `irq` is high exactly while bit 4 is set and the `irq_en` input is high.
- R8: While bit 6 (pseudo-idle) is set and a conversion is busy, `cpu_suspend` is high. Hardware clears bit 6 when the conversion completes.
- R9: `standby` equals the inverse of bit 5. Clearing bit 5 during a conversion aborts it: the busy bit clears, bit 4 is not set, and the result is unchanged.
- R10: Bit 0 = 1 selects channel 0 and bit 0 = 0 selects channel 1. The channel is the value written together with the start bit, and later writes to bit 0 do not affect a running conversion.
- R11: At completion, `result_hi` takes sample bits 9 to 2 and `result_lo` takes sample bits 1 to 0. Both hold until the next completion.
- R12: Divider register bits 4 to 0 set the conversion tick period to (value+1) system clocks. The values 0 and 31 both work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data, combinational on `sfr_addr` |
| irq_en | input | 1 | Interrupt enable for the end-of-conversion flag |
| ch0_sample | input | 10 | Digital sample standing in for channel 0 |
| ch1_sample | input | 10 | Digital sample standing in for channel 1 |
| result_hi | output | 8 | Upper 8 bits of the last result |
| result_lo | output | 2 | Lower 2 bits of the last result |
| irq | output | 1 | Interrupt request |
| cpu_suspend | output | 1 | Pseudo-idle request to the CPU |
| standby | output | 1 | Low-power standby request to the converter |

## Verification
The bench builds the block with its default parameters: an 8-bit register bus, a 10-bit result, a 5-bit divider and 11 ticks per conversion. These values bring both ends of the divider range within reach. A divider of 0 gives an 11-clock conversion and a divider of 31 gives a 352-clock conversion, so both can be timed to the exact cycle. Because the end of every conversion falls on a known edge, a software clear of the flag can be placed on that same edge.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  // Control register bit positions (software-visible layout)
  localparam int CB_CHSEL = 0;
  localparam int CB_START = 3;
  localparam int CB_EOC   = 4;
  localparam int CB_EN    = 5;
  localparam int CB_PIDLE = 6;
  localparam int SFR_W    = 8;
endpackage

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
  import adc_ctl_pkg::*;
#(
  parameter logic [7:0] ADDR_CTRL = 8'hF3,
  parameter logic [7:0] ADDR_DIV  = 8'hF2,
  parameter int         DIV_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sfr_wr,
  input  logic [7:0]       sfr_addr,
  input  logic [7:0]       sfr_wdata,
  output logic [7:0]       sfr_rdata,
  input  logic             busy,
  input  logic             conv_done,
  input  logic             conv_abort,
  output logic             en,
  output logic             pidle,
  output logic             eoc,
  output logic             chsel,
  output logic [DIV_W-1:0] div,
  output logic             start_req,
  output logic             start_ch
);

  logic             wr_ctrl, wr_div;
  logic             en_q, en_d;
  logic             pidle_q, pidle_d;
  logic             eoc_q, eoc_d;
  logic             chsel_q, chsel_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [SFR_W-1:0] ctrl_img, div_img;
  logic             wdata_unused;

  assign wdata_unused = &{1'b0, sfr_wdata};

  always_comb begin
    wr_ctrl = sfr_wr && (sfr_addr == ADDR_CTRL);
    wr_div  = sfr_wr && (sfr_addr == ADDR_DIV);

    en_d    = wr_ctrl ? sfr_wdata[CB_EN]    : en_q;
    chsel_d = wr_ctrl ? sfr_wdata[CB_CHSEL] : chsel_q;
    div_d   = wr_div  ? sfr_wdata[DIV_W-1:0] : div_q;

    pidle_d = wr_ctrl ? sfr_wdata[CB_PIDLE] : pidle_q;
    if (conv_done || conv_abort)
      pidle_d = 1'b0;

    eoc_d = eoc_q;
    if (wr_ctrl && !sfr_wdata[CB_EOC])
      eoc_d = 1'b0;
    if (conv_done)
      eoc_d = 1'b1;

    start_req = wr_ctrl && sfr_wdata[CB_START] && sfr_wdata[CB_EN] && !busy;
    start_ch  = sfr_wdata[CB_CHSEL];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pidle_q <= 1'b0;
      eoc_q   <= 1'b0;
      chsel_q <= 1'b0;
      div_q   <= '0;
    end else begin
      en_q    <= en_d;
      pidle_q <= pidle_d;
      eoc_q   <= eoc_d;
      chsel_q <= chsel_d;
      div_q   <= div_d;
    end
  end

  always_comb begin
    ctrl_img           = '0;
    ctrl_img[CB_CHSEL] = chsel_q;
    ctrl_img[CB_START] = busy;
    ctrl_img[CB_EOC]   = eoc_q;
    ctrl_img[CB_EN]    = en_q;
    ctrl_img[CB_PIDLE] = pidle_q;
    div_img            = '0;
    div_img[DIV_W-1:0] = div_q;
    if (sfr_addr == ADDR_CTRL)
      sfr_rdata = ctrl_img;
    else if (sfr_addr == ADDR_DIV)
      sfr_rdata = div_img;
    else
      sfr_rdata = '0;
  end

  assign en    = en_q;
  assign pidle = pidle_q;
  assign eoc   = eoc_q;
  assign chsel = chsel_q;
  assign div   = div_q;

endmodule

// File: rtl/adc_conv_clkdiv.sv
module adc_conv_clkdiv #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = run && (cnt_q == div);
    if (!run || tick)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int RES_W      = 10,
  parameter int CONV_TICKS = 11,
  parameter int TCNT_W     = $clog2(CONV_TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start_req,
  input  logic              start_ch,
  input  logic              tick,
  input  logic [RES_W-1:0]  ch0_sample,
  input  logic [RES_W-1:0]  ch1_sample,
  output logic              busy,
  output logic              done,
  output logic              abort,
  output logic [TCNT_W-1:0] tcnt,
  output logic [RES_W-1:0]  result
);

  localparam logic [TCNT_W-1:0] LAST_TICK = TCNT_W'(CONV_TICKS - 1);

  logic              busy_q, busy_d;
  logic              ch_q, ch_d;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d;
  logic [RES_W-1:0]  res_q, res_d;
  logic [RES_W-1:0]  picked;

  always_comb begin
    done   = busy_q && en && tick && (tcnt_q == LAST_TICK);
    abort  = busy_q && !en;
    picked = ch_q ? ch0_sample : ch1_sample;

    busy_d = busy_q;
    ch_d   = ch_q;
    tcnt_d = tcnt_q;
    res_d  = res_q;

    if (start_req) begin
      busy_d = 1'b1;
      ch_d   = start_ch;
      tcnt_d = '0;
    end else if (done) begin
      busy_d = 1'b0;
      tcnt_d = '0;
      res_d  = picked;
    end else if (abort) begin
      busy_d = 1'b0;
      tcnt_d = '0;
    end else if (busy_q && tick) begin
      tcnt_d = tcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ch_q   <= 1'b0;
      tcnt_q <= '0;
      res_q  <= '0;
    end else begin
      busy_q <= busy_d;
      ch_q   <= ch_d;
      tcnt_q <= tcnt_d;
      res_q  <= res_d;
    end
  end

  assign busy   = busy_q;
  assign tcnt   = tcnt_q;
  assign result = res_q;

endmodule

// File: rtl/adc_ctl_unit.sv
module adc_ctl_unit #(
  parameter logic [7:0] ADDR_CTRL  = 8'hF3,
  parameter logic [7:0] ADDR_DIV   = 8'hF2,
  parameter int         RES_W      = 10,
  parameter int         DIV_W      = 5,
  parameter int         CONV_TICKS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sfr_wr,
  input  logic [7:0]       sfr_addr,
  input  logic [7:0]       sfr_wdata,
  output logic [7:0]       sfr_rdata,
  input  logic             irq_en,
  input  logic [RES_W-1:0] ch0_sample,
  input  logic [RES_W-1:0] ch1_sample,
  output logic [7:0]       result_hi,
  output logic [RES_W-9:0] result_lo,
  output logic             irq,
  output logic             cpu_suspend,
  output logic             standby
);

  localparam int TCNT_W = $clog2(CONV_TICKS);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              busy_w, done_w, abort_w;
  logic              en_w, pidle_w, eoc_w, chsel_w;
  logic [DIV_W-1:0]  div_w;
  logic              start_req_w, start_ch_w, tick_w;
  logic [TCNT_W-1:0] tcnt_w;
  logic [RES_W-1:0]  result_w;
  logic              chsel_unused;

  // Reset: asserted at once, released after two clean clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  adc_ctl_regs #(
    .ADDR_CTRL (ADDR_CTRL),
    .ADDR_DIV  (ADDR_DIV),
    .DIV_W     (DIV_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sfr_wr     (sfr_wr),
    .sfr_addr   (sfr_addr),
    .sfr_wdata  (sfr_wdata),
    .sfr_rdata  (sfr_rdata),
    .busy       (busy_w),
    .conv_done  (done_w),
    .conv_abort (abort_w),
    .en         (en_w),
    .pidle      (pidle_w),
    .eoc        (eoc_w),
    .chsel      (chsel_w),
    .div        (div_w),
    .start_req  (start_req_w),
    .start_ch   (start_ch_w)
  );

  adc_conv_clkdiv #(
    .DIV_W (DIV_W)
  ) u_clkdiv (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (busy_w),
    .div   (div_w),
    .tick  (tick_w)
  );

  adc_conv_seq #(
    .RES_W      (RES_W),
    .CONV_TICKS (CONV_TICKS),
    .TCNT_W     (TCNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en         (en_w),
    .start_req  (start_req_w),
    .start_ch   (start_ch_w),
    .tick       (tick_w),
    .ch0_sample (ch0_sample),
    .ch1_sample (ch1_sample),
    .busy       (busy_w),
    .done       (done_w),
    .abort      (abort_w),
    .tcnt       (tcnt_w),
    .result     (result_w)
  );

  assign chsel_unused = chsel_w;

  assign result_hi   = result_w[RES_W-1:RES_W-8];
  assign result_lo   = result_w[RES_W-9:0];
  assign irq         = eoc_w && irq_en;
  assign cpu_suspend = pidle_w && busy_w;
  assign standby     = !en_w;

endmodule

// File: rtl/adc_ctl_chk.sv
module adc_ctl_chk #(
  parameter logic [7:0] ADDR_CTRL  = 8'hF3,
  parameter int         CONV_TICKS = 11,
  parameter int         TCNT_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sfr_wr,
  input logic [7:0]        sfr_addr,
  input logic [7:0]        sfr_wdata,
  input logic [7:0]        sfr_rdata,
  input logic              busy,
  input logic              eoc,
  input logic              en,
  input logic              pidle,
  input logic              standby,
  input logic [TCNT_W-1:0] tcnt
);

  logic wr_ctrl;
  assign wr_ctrl = sfr_wr && (sfr_addr == ADDR_CTRL);

  a_r2_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == ADDR_CTRL) |-> (sfr_rdata[7] == 1'b0 && sfr_rdata[2:1] == 2'b00));

  a_r3_tick_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(tcnt) < CONV_TICKS));

  a_r4_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !sfr_wdata[5] && !busy) |=> !busy);

  a_r6_eoc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !(wr_ctrl && !sfr_wdata[4])) |=> eoc);

  a_r6_eoc_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(en)) |-> eoc);

  a_r8_pidle_released: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !pidle);

  a_r9_standby_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !wr_ctrl) |=> !busy);

endmodule

bind adc_ctl_unit adc_ctl_chk #(
  .ADDR_CTRL  (ADDR_CTRL),
  .CONV_TICKS (CONV_TICKS),
  .TCNT_W     ($clog2(CONV_TICKS))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sfr_wr    (sfr_wr),
  .sfr_addr  (sfr_addr),
  .sfr_wdata (sfr_wdata),
  .sfr_rdata (sfr_rdata),
  .busy      (busy_w),
  .eoc       (eoc_w),
  .en        (en_w),
  .pidle     (pidle_w),
  .standby   (standby),
  .tcnt      (tcnt_w)
);

// File: tb/test_adc_ctl_unit.sv
module test_adc_ctl_unit;

  localparam int         CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL     = 8'hF3;
  localparam logic [7:0] A_DIV      = 8'hF2;
  localparam int         TICKS      = 11;
  localparam int         NVEC       = 6;

  // {div[4:0], chsel, irq_en, ch0[9:0], ch1[9:0]}
  localparam logic [26:0] VECS [NVEC] = '{
    {5'd0,  1'b1, 1'b1, 10'h3FF, 10'h000},
    {5'd0,  1'b0, 1'b0, 10'h155, 10'h2AA},
    {5'd3,  1'b1, 1'b1, 10'h001, 10'h3FE},
    {5'd31, 1'b0, 1'b1, 10'h200, 10'h1C3},
    {5'd7,  1'b1, 1'b0, 10'h2D6, 10'h129},
    {5'd1,  1'b0, 1'b1, 10'h0F0, 10'h30F}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       irq_en = 1'b0;
  logic [9:0] ch0_sample = 10'h000;
  logic [9:0] ch1_sample = 10'h000;
  logic [7:0] result_hi;
  logic [1:0] result_lo;
  logic       irq, cpu_suspend, standby;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ctl_unit i_adc_ctl_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .sfr_wr      (sfr_wr),
    .sfr_addr    (sfr_addr),
    .sfr_wdata   (sfr_wdata),
    .sfr_rdata   (sfr_rdata),
    .irq_en      (irq_en),
    .ch0_sample  (ch0_sample),
    .ch1_sample  (ch1_sample),
    .result_hi   (result_hi),
    .result_lo   (result_lo),
    .irq         (irq),
    .cpu_suspend (cpu_suspend),
    .standby     (standby)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr  = a;
    sfr_wdata = d;
    sfr_wr    = 1'b1;
    @(negedge clk);
    sfr_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    sfr_addr = a;
    #1;
    d = sfr_rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    sfr_addr = A_CTRL;
    #1;
    while (sfr_rdata[3]) begin
      @(negedge clk);
      #1;
      n++;
    end
  endtask

  initial begin
    logic [7:0] r;
    int         cyc;
    logic [9:0] expv;
    logic [9:0] held;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    rd(A_CTRL, r); check("R1 ctrl reset", r, 8'h00);
    rd(A_DIV, r);  check("R1 div reset", r, 8'h00);
    check("R1 standby", standby, 1);
    check("R1 irq/suspend", {irq, cpu_suspend}, 0);
    check("R1 result", {result_hi, result_lo}, 0);

    // Table-driven conversions
    for (int i = 0; i < NVEC; i++) begin
      logic [4:0] dv;
      logic       ch, ie;
      logic [9:0] s0, s1;
      {dv, ch, ie, s0, s1} = VECS[i];
      ch0_sample = s0;
      ch1_sample = s1;
      irq_en     = ie;
      wr(A_DIV, {3'b000, dv});
      wr(A_CTRL, {7'b0010100, ch});
      rd(A_CTRL, r);
      check("R3 busy after start", r[3], 1);
      check("R9 standby low when enabled", standby, 0);
      wait_idle(cyc);
      check("R3 R12 conversion length", cyc, TICKS * (dv + 1));
      expv = ch ? s0 : s1;
      check("R10 R11 result_hi", result_hi, expv[9:2]);
      check("R11 result_lo", result_lo, expv[1:0]);
      rd(A_CTRL, r);
      check("R6 eoc set", r[4], 1);
      check("R7 irq follows enable", irq, ie);
      wr(A_CTRL, 8'h20);
      rd(A_CTRL, r);
      check("R6 eoc cleared by write 0", r[4], 0);
    end

    // R2: reserved bits and unmapped address
    wr(A_CTRL, 8'h86);
    rd(A_CTRL, r); check("R2 ctrl reserved", r, 8'h00);
    wr(A_DIV, 8'hFF);
    rd(A_DIV, r);  check("R2 div reserved", r, 8'h1F);
    wr(8'h10, 8'hFF);
    rd(8'h10, r);  check("R2 unmapped", r, 8'h00);
    wr(A_DIV, 8'h00);

    // R4: start while disabled
    wr(A_CTRL, 8'h09);
    rd(A_CTRL, r); check("R4 start ignored", r[3], 0);
    repeat (15) @(negedge clk);
    rd(A_CTRL, r); check("R4 no eoc", r[4], 0);
    check("R9 standby when disabled", standby, 1);

    // R5: restart while busy has no effect
    wr(A_DIV, 8'h01);
    wr(A_CTRL, 8'h29);
    repeat (4) @(negedge clk);
    wr(A_CTRL, 8'h28);
    wait_idle(cyc);
    check("R5 length unchanged", cyc + 5, 22);
    wr(A_CTRL, 8'h21);

    // R6: write 1 leaves eoc alone
    wr(A_DIV, 8'h00);
    wr(A_CTRL, 8'h29);
    wait_idle(cyc);
    wr(A_CTRL, 8'h31);
    rd(A_CTRL, r); check("R6 write 1 keeps eoc", r[4], 1);
    wr(A_CTRL, 8'h21);
    rd(A_CTRL, r); check("R6 write 0 clears", r[4], 0);

    // R6: clear landing on the completing edge loses
    wr(A_CTRL, 8'h29);
    repeat (TICKS - 1) @(negedge clk);
    wr(A_CTRL, 8'h21);
    rd(A_CTRL, r); check("R6 set wins over clear", r[4:3], 2'b10);
    wr(A_CTRL, 8'h21);

    // R8: pseudo-idle
    wr(A_DIV, 8'h02);
    wr(A_CTRL, 8'h69);
    @(negedge clk);
    check("R8 suspend during conversion", cpu_suspend, 1);
    wait_idle(cyc);
    rd(A_CTRL, r); check("R8 pidle cleared", r[6], 0);
    check("R8 suspend released", cpu_suspend, 0);
    wr(A_CTRL, 8'h21);

    // R10: channel latched at start
    ch0_sample = 10'h0A5;
    ch1_sample = 10'h35A;
    wr(A_CTRL, 8'h29);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 8'h20);
    wait_idle(cyc);
    check("R10 channel latched", {result_hi, result_lo}, 10'h0A5);
    wr(A_CTRL, 8'h20);

    // R9: abort by disabling
    held = {result_hi, result_lo};
    ch1_sample = 10'h111;
    wr(A_DIV, 8'h03);
    wr(A_CTRL, 8'h28);
    repeat (8) @(negedge clk);
    wr(A_CTRL, 8'h00);
    repeat (3) @(negedge clk);
    rd(A_CTRL, r);
    check("R9 abort busy/eoc", r[4:3], 2'b00);
    check("R9 result kept", {result_hi, result_lo}, held);
    check("R9 standby after disable", standby, 1);

    // R7: irq gated by enable
    wr(A_DIV, 8'h00);
    wr(A_CTRL, 8'h29);
    wait_idle(cyc);
    irq_en = 1'b0; #1;
    check("R7 irq masked", irq, 0);
    irq_en = 1'b1; #1;
    check("R7 irq raised", irq, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule